// File: doc/BRIEF.md
# Word-to-byte serial transmitter

This block accepts 32-bit words from a local bus through a valid/ready handshake. It sends each word on a single serial line as four asynchronous serial frames of 8 bits each. A core clock of 24 MHz and a bit rate of 115200 baud are the default target. Bit timing comes from a plain counter that wraps at the clock-to-bit-rate ratio, which is 208 by default. There is no oversampling clock. The line rests high between words. A busy flag shows when a word is in flight.

A controller, for example a debug or telemetry path, presents a word together with a valid strobe. The block takes the word in the cycle where valid and ready are both high. It then drops ready and shifts the whole word out, least significant byte first. Ready returns when the last stop bit has been sent.

The control is a four-state machine:
- `ST_IDLE`: the line is high and ready is asserted.
- `ST_START`: the start bit.
- `ST_DATA`: the eight data bits.
- `ST_STOP`: the stop bit.

Its transitions are:
- accept (`ST_IDLE`→`ST_START` on valid).
- start done (`ST_START`→`ST_DATA` on a bit tick).
- byte done (`ST_DATA`→`ST_STOP` on the tick of the eighth data bit).
- next byte (`ST_STOP`→`ST_START` on a tick when more bytes remain).
- word done (`ST_STOP`→`ST_IDLE` on the tick of the fourth stop bit).

Top module: `word_uart_tx`

## Requirements
- R1: `word_ready` is high exactly when the block is idle. A word is taken on the rising clock edge where `word_valid` and `word_ready` are both high. `busy` is the inverse of `word_ready`.
- R2: Every serial bit, start, data or stop, holds the line for exactly `CLK_DIV` clock cycles. The default is 208. The bit counter restarts when a word is accepted.
- R3: Each frame is a start bit of value 0, then eight data bits with bit 0 first, then a stop bit of value 1. The start bit appears in the cycle after the accepting edge.
- R4: The four bytes of a word go out in the order bits [7:0], [15:8], [23:16], [31:24]. Each byte's start bit follows the previous stop bit with no gap.
- R5: After acceptance, `word_ready` stays low until the end of the fourth stop bit. It goes high exactly 40·`CLK_DIV` cycles after the accepting edge.
- R6: While idle the line is high. A `word_valid` or a `word_data` change during a transfer has no effect on the word being sent.
- R7: Reset (`rst_n` low, asynchronous) forces the line high and `word_ready` high. It also discards any partly sent word, and the next accepted word is sent whole.
- R8: A word held valid while a transfer ends is accepted on the first edge at which `word_ready` is high. Its start bit follows one idle-high cycle after the previous stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Word offered |
| word_data | input | 32 | Word to send |
| word_ready | output | 1 | Block can take a word |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A word is being sent |

## Verification
The end of a word's last stop bit and the acceptance of the next word can fall on adjacent edges. The bench provokes this by raising `word_valid` with a second word during the first transfer and holding it. It judges that the first word arrives unaltered and that ready rises exactly 40·`CLK_DIV` cycles after the first acceptance. It also checks that the second word is taken on the next edge and decodes correctly. A reset arriving in the middle of a byte is provoked separately, and the bench checks that the line returns high and that the following word is sent whole.

// File: rtl/word_uart_pkg.sv
package word_uart_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/word_uart_baud.sv
module word_uart_baud #(
    parameter int CLK_DIV = 208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2: the counter never runs past the divisor
    p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R2: ticks are isolated single cycles
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !restart |=> !tick);
endmodule

// File: rtl/word_uart_shreg.sv
module word_uart_shreg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              lsb
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= din;
        else if (shift)
            sr <= {1'b0, sr[WORD_W-1:1]};
    end

    assign lsb = sr[0];
endmodule

// File: rtl/word_uart_tx.sv
module word_uart_tx
    import word_uart_pkg::*;
#(
    parameter int CLK_DIV    = 208,
    parameter int WORD_BYTES = 4,
    parameter int BYTE_BITS  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            word_valid,
    input  logic [WORD_BYTES*BYTE_BITS-1:0] word_data,
    output logic                            word_ready,
    output logic                            tx_line,
    output logic                            busy
);
    localparam int WORD_W = WORD_BYTES * BYTE_BITS;
    localparam int BW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam int YW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_BITS - 1);
    localparam logic [YW-1:0] BYTE_LAST = YW'(WORD_BYTES - 1);

    tx_state_t     state, state_nx;
    logic [BW-1:0] bit_idx;
    logic [YW-1:0] byte_idx;
    logic          bit_tick;
    logic          data_bit;
    logic          accept;
    logic          word_end;

    assign accept   = word_valid && (state == ST_IDLE);
    assign word_end = (state == ST_STOP) && bit_tick && (byte_idx == BYTE_LAST);

    word_uart_baud #(.CLK_DIV(CLK_DIV)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (bit_tick)
    );

    word_uart_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift ((state == ST_DATA) && bit_tick),
        .din   (word_data),
        .lsb   (data_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (word_valid) state_nx = ST_START;
            ST_START: if (bit_tick)   state_nx = ST_DATA;
            ST_DATA:  if (bit_tick && bit_idx == BIT_LAST) state_nx = ST_STOP;
            ST_STOP:  if (bit_tick)
                          state_nx = (byte_idx == BYTE_LAST) ? ST_IDLE : ST_START;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // bit and byte position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            byte_idx <= '0;
        end else if (accept) begin
            bit_idx  <= '0;
            byte_idx <= '0;
        end else if (bit_tick) begin
            if (state == ST_DATA)
                bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
            if (state == ST_STOP && byte_idx != BYTE_LAST)
                byte_idx <= byte_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE:  tx_line = 1'b1;
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = data_bit;
            ST_STOP:  tx_line = 1'b1;
            default:  tx_line = 1'b1;
        endcase
        word_ready = (state == ST_IDLE);
        busy       = (state != ST_IDLE);
    end

    // R5: acceptance makes the block busy on the next cycle
    p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R5: ready stays low until the final stop bit ends
    p_hold_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ready && !word_end |=> !word_ready);
    // R3: a transfer opens with the start bit
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);
    // R2: the line only moves on a bit boundary
    p_line_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bit_tick |=> $stable(tx_line));
    // R6: idle line is high
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);
endmodule

// File: tb/word_uart_tx_tb.sv
module word_uart_tx_tb;
    localparam int DIV = 16;
    localparam int NV  = 5;
    localparam logic [31:0] VEC [NV] = '{
        32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF, 32'hA55A_C33C, 32'h8000_0001
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready, tx_line, busy;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    word_uart_tx #(.CLK_DIV(DIV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .tx_line    (tx_line),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a word; returns at the first negedge after the accepting edge.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        while (!word_ready) @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        @(posedge clk);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    // Called at the first negedge after acceptance; decodes 40 bits mid-bit.
    task automatic recv(input logic [31:0] exp);
        logic [31:0] got = '0;
        logic [3:0]  frame_bad = '0;
        chk(!word_ready && busy, "R1", {30'd0, word_ready, busy}, 32'd1);
        repeat (DIV/2 - 1) @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            if (k > 0) repeat (DIV) @(negedge clk);
            if (k % 10 == 0 && tx_line != 1'b0) frame_bad[k/10] = 1'b1;
            else if (k % 10 == 9 && tx_line != 1'b1) frame_bad[k/10] = 1'b1;
            else if (k % 10 != 0 && k % 10 != 9) got[(k/10)*8 + (k%10) - 1] = tx_line;
        end
        for (int b = 0; b < 4; b++)
            chk(!frame_bad[b], "R3 start/stop", {31'd0, frame_bad[b]}, 32'd0);
        chk(got == exp, "R4 word order", got, exp);
        repeat (DIV/2) @(negedge clk);
        chk(!word_ready, "R5 ready low before end", {31'd0, word_ready}, 32'd0);
        @(negedge clk);
        chk(word_ready, "R5 ready at 40*DIV", {31'd0, word_ready}, 32'd1);
        chk(tx_line, "R6 idle high", {31'd0, tx_line}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_line && word_ready && !busy, "R7 reset state",
            {29'd0, tx_line, word_ready, busy}, 32'd6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_ready && !busy, "R1 idle ready", {30'd0, word_ready, busy}, 32'd2);

        // table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i]);
            recv(VEC[i]);
        end

        // R2 / R3: start bit edge and exact bit width
        send(32'h0000_0001);
        chk(!tx_line, "R3 start follows accept", {31'd0, tx_line}, 32'd0);
        repeat (DIV - 1) @(negedge clk);
        chk(!tx_line, "R2 start bit lasts DIV", {31'd0, tx_line}, 32'd0);
        @(negedge clk);
        chk(tx_line, "R2 data bit after DIV", {31'd0, tx_line}, 32'd1);
        while (!word_ready) @(negedge clk);

        // R6 / R8: data change while busy, then back-to-back acceptance
        send(32'hCAFE_0F0F);
        word_valid = 1'b1;
        word_data  = 32'h1357_9BDF;
        recv(32'hCAFE_0F0F);
        @(negedge clk);
        word_valid = 1'b0;
        recv(32'h1357_9BDF);
        chk(1'b1, "R8 back-to-back done", 32'd0, 32'd0);

        // R7: reset mid-byte discards the word
        send(32'h0000_0000);
        repeat (3*DIV) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tx_line && word_ready && !busy, "R7 reset mid-word",
            {29'd0, tx_line, word_ready, busy}, 32'd6);
        rst_n = 1'b1;
        repeat (2*DIV) @(negedge clk);
        chk(tx_line && word_ready, "R7 stays idle", {30'd0, tx_line, word_ready}, 32'd3);
        send(32'hDEAD_BEEF);
        recv(32'hDEAD_BEEF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule